// File: doc/BRIEF.md
# Effective Address Generator

This block forms a 16-bit effective address for a small load/store processor by adding a base value to a sign-extended immediate taken from the instruction word. The base is either the program counter or the first source-register read value. The immediate is zero or one of three signed fields of the instruction word. The program counter has already been advanced past the current instruction during execute, so PC-relative results point relative to the following instruction.

The sum is always present on `ea_out`, which feeds the memory-address register mux. A second copy, `bus_out`, carries the address onto the shared datapath bus only while `mar_drive` is high. When `mar_drive` is low, `bus_out` is zero, so the bus can be modelled as an OR of gated sources. The unit is purely combinational.

Top module: `ea_gen`

## Requirements
- R1: With `base_sel` = 0 the base operand is `pc_val`.
- R2: With `base_sel` = 1 the base operand is `sr1_val`.
- R3: With `imm_sel` = 2'b00 the immediate is zero, so `ea_out` equals the selected base.
- R4: With `imm_sel` = 2'b01 the immediate is `ir_word[5:0]` sign-extended from bit 5.
- R5: With `imm_sel` = 2'b10 the immediate is `ir_word[8:0]` sign-extended from bit 8.
- R6: With `imm_sel` = 2'b11 the immediate is `ir_word[10:0]` sign-extended from bit 10.
- R7: The addition wraps modulo 2^16 and produces no carry or overflow indication.
- R8: While `mar_drive` = 1, `bus_out` equals `ea_out`.
- R9: While `mar_drive` = 0, `bus_out` is 16'h0000 whatever the other inputs are.
- R10: The outputs follow the inputs with no register stage: a new input set is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ir_word | input | 16 | Instruction word holding the offset fields |
| pc_val | input | 16 | Program counter, already incremented |
| sr1_val | input | 16 | First source-register read value |
| base_sel | input | 1 | Base select: 0 PC, 1 register |
| imm_sel | input | 2 | Immediate select: 00 zero, 01 6-bit, 10 9-bit, 11 11-bit |
| mar_drive | input | 1 | Gate the address onto the bus |
| ea_out | output | 16 | Effective address to the address-register mux |
| bus_out | output | 16 | Gated copy for the shared bus, zero when not driving |

## Verification
The two behaviours that meet in one evaluation are a negative sign-extended offset and wrap-around of the sum past 16'hFFFF or below zero, both while the bus gate is toggling. The bench provokes this with directed vectors that put a base near either end of the range against offsets of each width at their most negative and most positive values, and with random instruction words and bases under all select combinations. Each result is judged against a bench-side reference sum taken modulo 2^16, and against the gated bus value computed from the drive bit.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int W = 16
) (
  input  logic [15:0]  ir_word,
  input  logic [W-1:0] pc_val,
  input  logic [W-1:0] sr1_val,
  input  logic         base_sel,
  input  logic [1:0]   imm_sel,
  input  logic         mar_drive,
  output logic [W-1:0] ea_out,
  output logic [W-1:0] bus_out
);

  logic [W-1:0] base_op;
  logic [W-1:0] imm_op;

  assign base_op = base_sel ? sr1_val : pc_val;

  always_comb begin
    case (imm_sel)
      2'b00:   imm_op = '0;
      2'b01:   imm_op = {{(W-6){ir_word[5]}},  ir_word[5:0]};
      2'b10:   imm_op = {{(W-9){ir_word[8]}},  ir_word[8:0]};
      default: imm_op = {{(W-11){ir_word[10]}}, ir_word[10:0]};
    endcase
  end

  assign ea_out  = base_op + imm_op;
  assign bus_out = mar_drive ? ea_out : '0;

endmodule

module ea_gen_chk #(
  parameter int W = 16
) (
  input logic [15:0]  ir_word,
  input logic [W-1:0] pc_val,
  input logic [W-1:0] sr1_val,
  input logic         base_sel,
  input logic [1:0]   imm_sel,
  input logic         mar_drive,
  input logic [W-1:0] ea_out,
  input logic [W-1:0] bus_out
);

  logic [W-1:0] diff_pc;
  logic [W-1:0] diff_sr;
  assign diff_pc = ea_out - pc_val;
  assign diff_sr = ea_out - sr1_val;

  always_comb begin
    // R3
    zero_imm_chk: assert (imm_sel != 2'b00 || ea_out == (base_sel ? sr1_val : pc_val));
    // R1
    pc_base_chk: assert (base_sel || imm_sel != 2'b01 ||
                         $signed(diff_pc) == W'($signed(ir_word[5:0])));
    // R2
    reg_base_chk: assert (!base_sel || imm_sel != 2'b10 ||
                          $signed(diff_sr) == W'($signed(ir_word[8:0])));
    // R6
    off11_chk: assert (imm_sel != 2'b11 ||
                       (base_sel ? diff_sr : diff_pc) == W'($signed(ir_word[10:0])));
    // R8
    bus_drive_chk: assert (!mar_drive || bus_out == ea_out);
    // R9
    bus_idle_chk: assert (mar_drive || bus_out == '0);
  end

endmodule

bind ea_gen ea_gen_chk #(.W(W)) u_ea_gen_chk (.*);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] ir_word, pc_val, sr1_val, ea_out, bus_out;
  logic        base_sel, mar_drive;
  logic [1:0]  imm_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ea_gen u_ea_gen (.*);

  function automatic logic [15:0] exp_imm(input logic [15:0] ir, input logic [1:0] s);
    case (s)
      2'b00:   return 16'h0000;
      2'b01:   return 16'($signed(ir[5:0]));
      2'b10:   return 16'($signed(ir[8:0]));
      default: return 16'($signed(ir[10:0]));
    endcase
  endfunction

  function automatic logic [15:0] exp_ea(input logic [15:0] ir, input logic [15:0] pc,
                                         input logic [15:0] r, input logic b, input logic [1:0] s);
    int unsigned sum;
    sum = int'(b ? r : pc) + int'(exp_imm(ir, s));
    return sum[15:0];
  endfunction

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] ir, input logic [15:0] pc, input logic [15:0] r,
                       input logic b, input logic [1:0] s, input logic d, input string tag);
    logic [15:0] e;
    @(posedge clk);
    #1;
    ir_word = ir; pc_val = pc; sr1_val = r; base_sel = b; imm_sel = s; mar_drive = d;
    @(negedge clk);
    e = exp_ea(ir, pc, r, b, s);
    cmp({tag, " ea"}, ea_out, e);
    cmp(d ? "R8 bus" : "R9 bus", bus_out, d ? e : 16'h0000);
  endtask

  initial begin
    ir_word = 16'hFFFF; pc_val = 16'h1234; sr1_val = 16'h5678;
    base_sel = 1'b0; imm_sel = 2'b00; mar_drive = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R9 reset bus", bus_out, 16'h0000);
    cmp("R3 reset ea", ea_out, 16'h1234);

    apply(16'hFFFF, 16'h3000, 16'h8000, 1'b0, 2'b00, 1'b1, "R1 R3");
    apply(16'hFFFF, 16'h3000, 16'h8000, 1'b1, 2'b00, 1'b1, "R2 R3");
    apply(16'h0020, 16'h3000, 16'h0000, 1'b0, 2'b01, 1'b1, "R4 min6");
    apply(16'h001F, 16'h0000, 16'h4000, 1'b1, 2'b01, 1'b1, "R4 max6");
    apply(16'h0100, 16'h0000, 16'h0000, 1'b0, 2'b10, 1'b1, "R5 min9 R7");
    apply(16'h00FF, 16'hFFF0, 16'h0000, 1'b0, 2'b10, 1'b1, "R5 max9 R7");
    apply(16'h0400, 16'h0100, 16'h0000, 1'b0, 2'b11, 1'b1, "R6 min11 R7");
    apply(16'hFBFF, 16'hFC01, 16'h0000, 1'b0, 2'b11, 1'b1, "R6 max11 R7");
    apply(16'h0400, 16'h0000, 16'h0300, 1'b1, 2'b11, 1'b0, "R9 R2");
    apply(16'h003F, 16'hFFFF, 16'h0000, 1'b0, 2'b01, 1'b0, "R9 wrap");

    for (int i = 0; i < 3000; i++) begin
      apply(16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
            2'($urandom), 1'($urandom), "R10 rnd");
    end
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'd7341));
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule